// File: doc/BRIEF.md
# PCI Bridge Error Interrupt Status Register

This block holds three sticky error flags for a PCI bridge and raises one combined interrupt line toward the local processor. The bus logic delivers single-cycle event pulses for three conditions. The first is a system error signal seen while the bridge acts as host. The second is a data parity fault on a write received while the bridge acts as target. The third is a parity error report returned during a read served as target. A flag stays set until software clears it.

Each event is qualified before it may set its flag. The system error flag needs host mode. The two parity flags need target mode and the parity error response enable from the PCI command register. The local processor reads the flags and clears any subset of them with a byte-enabled write. A written 0 clears a flag and a written 1 leaves it alone. The PCI configuration side sees the same flags as read-only data, and its writes are discarded. A separate read/write mask register selects which flags drive the interrupt output.

Top module: `pci_err_status`

## Requirements
- R1: While reset is active, all three flags, the mask register and `irq` are 0.
- R2: A pulse on `ev_serr` while `host_mode`=1 sets flag bit 6, which then stays set. A pulse while `host_mode`=0 leaves bit 6 unchanged.
- R3: A pulse on `ev_wr_dpe` sets flag bit 5 only when `host_mode`=0 and `perr_resp_en`=1. Otherwise the pulse is ignored.
- R4: A pulse on `ev_rd_perr` sets flag bit 4 only when `host_mode`=0 and `perr_resp_en`=1. Otherwise the pulse is ignored.
- R5: A local write with `lcl_sel`=0 and `lcl_be[0]`=1 clears each of bits 6..4 whose data bit is 0 and keeps each one whose data bit is 1. With `lcl_be[0]`=0, the write changes nothing.
- R6: When a qualified event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: `pci_rdata` presents the flags at bits 6..4. A PCI write (`pci_wr`=1, any `pci_wdata`) changes no flag.
- R8: On `pci_rdata` and `lcl_rdata`, bits 31..7 and 3..0 always read 0.
- R9: A local write with `lcl_sel`=1 and `lcl_be[0]`=1 loads data bits 6..4 into the mask. `lcl_rdata` with `lcl_sel`=1 returns the mask at bits 6..4. `irq` is 1 exactly when some flag and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1: bridge is host; 0: bridge is target |
| perr_resp_en | input | 1 | Parity error response enable from the PCI command register |
| ev_serr | input | 1 | One-cycle pulse: system error seen |
| ev_wr_dpe | input | 1 | One-cycle pulse: data parity fault on a target write |
| ev_rd_perr | input | 1 | One-cycle pulse: parity error reported on a target read |
| lcl_wr | input | 1 | Local processor write strobe |
| lcl_sel | input | 1 | Local register select: 0 flags, 1 mask |
| lcl_be | input | 4 | Local write byte enables; only lane 0 matters |
| lcl_wdata | input | 32 | Local write data |
| pci_wr | input | 1 | PCI configuration write strobe (discarded) |
| pci_wdata | input | 32 | PCI configuration write data (discarded) |
| lcl_rdata | output | 32 | Local read data for the selected register |
| pci_rdata | output | 32 | PCI read data: the flag word |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench drives each event under every gating combination. A design that ignored host mode or the parity response enable would latch a flag that must stay 0. It issues writes of all ones, writes with lane 0 disabled and PCI writes. Each of these would wrongly clear flags in a design that cleared on 1, ignored byte enables or let the PCI side write. It collides an event with a clearing write on the same flag, so a design where the clear wins loses the event. It also walks the mask through single bits and all ones. A wrong OR, or reserved bits that leak, would show up on `irq` or in the readback.

// File: rtl/pcis_pkg.sv
package pcis_pkg;
  localparam int REG_W    = 32;
  localparam int BE_W     = REG_W / 8;
  localparam int NFLAG    = 3;
  localparam int FLAG_LSB = 4;   // flags occupy bits 6..4
  localparam int FL_RPERR = 0;   // word bit 4
  localparam int FL_WDPE  = 1;   // word bit 5
  localparam int FL_SERR  = 2;   // word bit 6

  function automatic logic [NFLAG-1:0] pick_flags(input logic [REG_W-1:0] w);
    return w[FLAG_LSB +: NFLAG];
  endfunction

  function automatic logic [REG_W-1:0] place_flags(input logic [NFLAG-1:0] f);
    logic [REG_W-1:0] w;
    w = '0;
    w[FLAG_LSB +: NFLAG] = f;
    return w;
  endfunction

  function automatic logic lane0_on(input logic [BE_W-1:0] be);
    return be[0];
  endfunction

  function automatic logic any_enabled(input logic [NFLAG-1:0] f,
                                       input logic [NFLAG-1:0] m);
    return |(f & m);
  endfunction
endpackage

// File: rtl/pcis_evt_qual.sv
module pcis_evt_qual
  import pcis_pkg::*;
(
  input  logic             host_mode,
  input  logic             perr_resp_en,
  input  logic             ev_serr,
  input  logic             ev_wr_dpe,
  input  logic             ev_rd_perr,
  output logic [NFLAG-1:0] set_vec
);
  logic tgt_parity_ok;
  assign tgt_parity_ok = !host_mode && perr_resp_en;

  always_comb begin
    set_vec           = '0;
    set_vec[FL_SERR]  = ev_serr && host_mode;
    set_vec[FL_WDPE]  = ev_wr_dpe && tgt_parity_ok;
    set_vec[FL_RPERR] = ev_rd_perr && tgt_parity_ok;
  end
endmodule

// File: rtl/pcis_flag_bank.sv
module pcis_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;   // set beats clear
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pcis_mask_reg.sv
module pcis_mask_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] din,
  output logic [N-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask <= '0;
    else if (load) mask <= din;
  end
endmodule

// File: rtl/pci_err_status.sv
module pci_err_status
  import pcis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic             perr_resp_en,
  input  logic             ev_serr,
  input  logic             ev_wr_dpe,
  input  logic             ev_rd_perr,
  input  logic             lcl_wr,
  input  logic             lcl_sel,
  input  logic [BE_W-1:0]  lcl_be,
  input  logic [REG_W-1:0] lcl_wdata,
  input  logic             pci_wr,
  input  logic [REG_W-1:0] pci_wdata,
  output logic [REG_W-1:0] lcl_rdata,
  output logic [REG_W-1:0] pci_rdata,
  output logic             irq
);
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] mask;
  logic             lane_hit;
  logic             flag_wr;
  logic             mask_ld;
  logic             pci_write_dropped;  // observed only by the checker

  assign lane_hit = lcl_wr && lane0_on(lcl_be);
  assign flag_wr  = lane_hit && !lcl_sel;
  assign mask_ld  = lane_hit && lcl_sel;
  assign clr_vec  = flag_wr ? ~pick_flags(lcl_wdata) : '0;
  assign pci_write_dropped = pci_wr && (pci_wdata != '0 || pci_wdata == '0);

  pcis_evt_qual u_qual (
    .host_mode    (host_mode),
    .perr_resp_en (perr_resp_en),
    .ev_serr      (ev_serr),
    .ev_wr_dpe    (ev_wr_dpe),
    .ev_rd_perr   (ev_rd_perr),
    .set_vec      (set_vec)
  );

  pcis_flag_bank #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  pcis_mask_reg #(.N(NFLAG)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mask_ld),
    .din   (pick_flags(lcl_wdata)),
    .mask  (mask)
  );

  assign pci_rdata = place_flags(flags);
  assign lcl_rdata = lcl_sel ? place_flags(mask) : place_flags(flags);
  assign irq       = any_enabled(flags, mask);
endmodule

// File: rtl/pci_err_status_chk.sv
module pci_err_status_chk
  import pcis_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_mode,
  input logic             perr_resp_en,
  input logic             ev_serr,
  input logic             ev_wr_dpe,
  input logic             ev_rd_perr,
  input logic             lcl_wr,
  input logic             lcl_sel,
  input logic [BE_W-1:0]  lcl_be,
  input logic [REG_W-1:0] lcl_wdata,
  input logic             pci_write_dropped,
  input logic [NFLAG-1:0] set_vec,
  input logic [NFLAG-1:0] clr_vec,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] mask,
  input logic [REG_W-1:0] lcl_rdata,
  input logic [REG_W-1:0] pci_rdata,
  input logic             irq
);
  localparam logic [REG_W-1:0] RSVD = ~place_flags('1);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (flags == '0 && mask == '0 && !irq); // R1
    end
  end

  AST_SERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_rdata[6]) |-> $past(ev_serr && host_mode)); // R2
  AST_WDPE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_rdata[5]) |-> $past(ev_wr_dpe && !host_mode && perr_resp_en)); // R3
  AST_RPERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_rdata[4]) |-> $past(ev_rd_perr && !host_mode && perr_resp_en)); // R4

  for (genvar i = 0; i < NFLAG; i++) begin : g_fall
    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(lcl_wr && !lcl_sel && lcl_be[0] && !lcl_wdata[FLAG_LSB+i])); // R5
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R6
  AST_PCI_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_write_dropped && set_vec == '0 && clr_vec == '0) |=> $stable(flags)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((pci_rdata & RSVD) == '0) && ((lcl_rdata & RSVD) == '0)); // R8
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_wr && lcl_sel && lcl_be[0]) |=> (mask == $past(lcl_wdata[6:4]))); // R9
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R9
endmodule

bind pci_err_status pci_err_status_chk u_chk (.*);

// File: tb/sim_pci_err_status.sv
module sim_pci_err_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b0, perr_resp_en = 1'b0;
  logic        ev_serr = 1'b0, ev_wr_dpe = 1'b0, ev_rd_perr = 1'b0;
  logic        lcl_wr = 1'b0, lcl_sel = 1'b0;
  logic [3:0]  lcl_be = '0;
  logic [31:0] lcl_wdata = '0;
  logic        pci_wr = 1'b0;
  logic [31:0] pci_wdata = '0;
  logic [31:0] lcl_rdata, pci_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [2:0]  m_stat = '0;   // {bit6, bit5, bit4}
  logic [2:0]  m_mask = '0;
  logic [31:0] q_word[$];
  logic        q_irq[$];
  string       q_req[$];

  always #4 clk = ~clk;   // 125 MHz

  pci_err_status u0 (.*);

  function automatic logic [31:0] word_of(input logic [2:0] f);
    return {25'd0, f, 4'd0};
  endfunction

  // monitor: compare expected items against the design, one per cycle
  always @(negedge clk) begin
    if (q_word.size() > 0) begin
      logic [31:0] ew;
      logic        ei;
      string       er;
      ew = q_word.pop_front();
      ei = q_irq.pop_front();
      er = q_req.pop_front();
      n_cmp++;
      if (pci_rdata !== ew || irq !== ei) begin
        n_bad++;
        $display("FAIL %s: pci_rdata=%h irq=%b expected %h irq=%b", er, pci_rdata, irq, ew, ei);
      end
    end
  end

  // driver: one cycle of stimulus, model update, push of the expectation
  task automatic step(input logic [2:0] ev, input logic host, input logic pre,
                      input logic wr, input logic sel, input logic [3:0] be,
                      input logic [31:0] wd, input logic pwr, input logic [31:0] pwd,
                      input string req);
    logic [2:0] set, clr;
    @(negedge clk);
    {ev_serr, ev_wr_dpe, ev_rd_perr} = ev;
    host_mode = host; perr_resp_en = pre;
    lcl_wr = wr; lcl_sel = sel; lcl_be = be; lcl_wdata = wd;
    pci_wr = pwr; pci_wdata = pwd;
    @(posedge clk);
    set = {ev[2] & host, ev[1] & ~host & pre, ev[0] & ~host & pre};
    clr = (wr && !sel && be[0]) ? ~wd[6:4] : 3'b000;
    m_stat = set | (m_stat & ~clr);
    if (wr && sel && be[0]) m_mask = wd[6:4];
    q_word.push_back(word_of(m_stat));
    q_irq.push_back(|(m_stat & m_mask));
    q_req.push_back(req);
  endtask

  task automatic idle(input string req);
    step(3'b000, host_mode, perr_resp_en, 1'b0, 1'b0, 4'h0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic rd_check(input logic sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    lcl_wr = 1'b0; pci_wr = 1'b0; {ev_serr, ev_wr_dpe, ev_rd_perr} = 3'b000;
    lcl_sel = sel;
    #1;
    n_cmp++;
    if (lcl_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: lcl_rdata=%h expected %h", req, lcl_rdata, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (pci_rdata !== 32'h0 || irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: pci_rdata=%h irq=%b expected 0 0", pci_rdata, irq);
    end
    rd_check(1'b1, 32'h0, "R1 mask after reset");
    rst_n = 1'b1;
    idle("R1");
    // R2: host gating and stickiness
    step(3'b100, 1, 1, 0, 0, 4'h0, 0, 0, 0, "R2 set in host mode");
    idle("R2 sticky");
    step(3'b100, 0, 1, 0, 0, 4'h0, 0, 0, 0, "R2 target pulse");
    step(3'b000, 0, 1, 1, 0, 4'h1, 32'hFFFF_FFBF, 0, 0, "R5 clear bit 6 only");
    step(3'b100, 0, 1, 0, 0, 4'h0, 0, 0, 0, "R2 ignored in target mode");
    // R3
    step(3'b010, 0, 0, 0, 0, 4'h0, 0, 0, 0, "R3 ignored with enable off");
    step(3'b010, 1, 1, 0, 0, 4'h0, 0, 0, 0, "R3 ignored in host mode");
    step(3'b010, 0, 1, 0, 0, 4'h0, 0, 0, 0, "R3 set");
    // R4
    step(3'b001, 0, 0, 0, 0, 4'h0, 0, 0, 0, "R4 ignored with enable off");
    step(3'b001, 1, 1, 0, 0, 4'h0, 0, 0, 0, "R4 ignored in host mode");
    step(3'b001, 0, 1, 0, 0, 4'h0, 0, 0, 0, "R4 set");
    // R5 / R7
    step(3'b000, 0, 1, 1, 0, 4'h1, 32'hFFFF_FFFF, 0, 0, "R5 ones keep flags");
    step(3'b000, 0, 1, 1, 0, 4'hE, 32'h0, 0, 0, "R5 lane 0 off no effect");
    step(3'b000, 0, 1, 0, 0, 4'h0, 0, 1, 32'h0, "R7 PCI zero write ignored");
    step(3'b000, 0, 1, 0, 0, 4'h0, 0, 1, 32'hFFFF_FFFF, "R7 PCI ones write ignored");
    // R6: set and clear on the same flag
    step(3'b100, 1, 1, 1, 0, 4'h1, 32'h0, 0, 0, "R6 set wins over clear");
    // R9: mask and irq
    step(3'b000, 1, 1, 1, 1, 4'h1, 32'h0000_0040, 0, 0, "R9 mask bit 6 raises irq");
    step(3'b000, 1, 1, 1, 1, 4'h1, 32'h0000_0020, 0, 0, "R9 mask bit 5 drops irq");
    step(3'b010, 0, 1, 0, 0, 4'h0, 0, 0, 0, "R9 masked flag raises irq");
    rd_check(1'b1, 32'h0000_0020, "R9 mask readback");
    rd_check(1'b0, 32'h0000_0060, "R8 flag readback");
    step(3'b000, 0, 1, 1, 1, 4'h1, 32'hFFFF_FFFF, 0, 0, "R9 mask all ones");
    rd_check(1'b1, 32'h0000_0070, "R8 reserved mask bits zero");
    step(3'b000, 0, 1, 1, 1, 4'h2, 32'h0, 0, 0, "R9 mask lane 0 off");
    rd_check(1'b1, 32'h0000_0070, "R9 mask kept");
    step(3'b000, 0, 1, 1, 0, 4'hF, 32'h0, 0, 0, "R5 clear all");
    idle("R9 irq low after clear");
    idle("flush");
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule